// File: doc/BRIEF.md
# Channel-Status Block Frame Sequencer

This block keeps track of where a digital audio transmitter is inside the 192-frame channel-status block. Each frame carries one stereo pair as two subframes. The block runs on the bit-slot clock, with one clock cycle per transmitted bit slot. Each subframe has 32 slots, so each frame has 64. After reset the block waits for the left/right frame-sync input to change from the left half to the right half. It then starts its slot and frame counters on that right-channel subframe. This alignment makes channel A always carry the left sample and channel B always carry the right sample.

Once running, the block gives the current frame index, the channel of the subframe being sent, and the preamble kind that the serialiser must send for that subframe. It also gives a block-start marker that helps an upstream source feed per-frame channel-status bits. The marker rises one bit slot before frame 0 begins and falls one bit slot before frame 128 begins. When the alternate subcode port is in use, the marker is held low. A line-driver enable stays low through reset and until alignment, which keeps the differential outputs grounded.

Top module: `cs_block_seq`

## Requirements
- R1: While `rst_n` is low, and after reset until alignment, `drv_en`=0, `blk_start`=0, `chan_b`=0, `frame_idx`=0 and `pre_sel`=0 (no preamble).
- R2: `fsync` high means left and low means right. Alignment happens on the first clock edge that samples `fsync` low after an edge that sampled it high, counting from reset release. In the next cycle `drv_en`=1, and the block sends slot 32 (the first right slot) of frame 191.
- R3: Each frame has 64 bit slots, one per clock cycle. `chan_b` is 0 during slots 0..31 (left, channel A) and 1 during slots 32..63 (right, channel B).
- R4: `frame_idx` increments after slot 63 and wraps from 191 to 0.
- R5: `pre_sel` codes are 0 = none, 1 = X, 2 = Y, 3 = Z. The left subframe of frame 0 gets Z, every other left subframe gets X, and every right subframe gets Y. The code stays the same for all 32 slots of a subframe.
- R6: `blk_start` becomes 1 in slot 63 of frame 191, one slot before the first preamble slot of frame 0.
- R7: `blk_start` becomes 0 in slot 63 of frame 127. It is therefore high for exactly 128×64 cycles in every block.
- R8: While `subcode_en`=1, `blk_start` reads 0 in the same cycle. The block-start schedule itself is not disturbed: once `subcode_en` returns to 0, `blk_start` again follows R6/R7 for the current position.
- R9: After alignment, changes on `fsync` have no effect on `frame_idx`, `chan_b`, `pre_sel`, `blk_start` or `drv_en` until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-slot clock, one cycle per transmitted slot |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Left/right frame sync: 1 = left, 0 = right |
| subcode_en | input | 1 | Subcode port in use; masks the block-start marker |
| frame_idx | output | 8 | Frame index within the block, 0..191 |
| chan_b | output | 1 | 0 = channel A (left), 1 = channel B (right) |
| pre_sel | output | 2 | Preamble code: 0 none, 1 X, 2 Y, 3 Z |
| blk_start | output | 1 | Block-start marker |
| drv_en | output | 1 | Line-driver enable; 0 grounds the differential outputs |

## Verification
The assertions assume that `rst_n` is held low over at least one clock edge. They also assume that `subcode_en` is an ordinary level, free to change in any cycle. They make no assumption about the shape of `fsync`, because after alignment it is ignored. The marker-length check counts cycles from the first rise after reset, so it also holds on a partial block that a reset cuts short. The stimulus aligns the block twice: once after the first reset and once after a reset in the middle of a block, each time with a different `fsync` phase. After alignment, `fsync` toggles at a period unrelated to the frame period, and `subcode_en` is pulsed across both the rising and the falling transition of the marker.

// File: rtl/cs_seq_pkg.sv
package cs_seq_pkg;

  typedef enum logic [1:0] {
    PRE_NONE = 2'd0,
    PRE_X    = 2'd1,
    PRE_Y    = 2'd2,
    PRE_Z    = 2'd3
  } preamble_e;

  // Preamble for the subframe currently on the line.
  function automatic preamble_e pick_preamble(input logic running,
                                              input logic right_half,
                                              input logic first_frame);
    if (!running)         return PRE_NONE;
    else if (right_half)  return PRE_Y;
    else if (first_frame) return PRE_Z;
    else                  return PRE_X;
  endfunction

  // Modular increment used by both position counters.
  function automatic int unsigned wrap_inc(input int unsigned value,
                                           input int unsigned limit);
    return (value + 1 >= limit) ? 0 : value + 1;
  endfunction

  // Linear slot position within a block.
  function automatic int unsigned block_pos(input int unsigned frame,
                                            input int unsigned slot,
                                            input int unsigned frame_slots);
    return frame * frame_slots + slot;
  endfunction

endpackage

// File: rtl/cs_fsync_align.sv
module cs_fsync_align (
  input  logic clk,
  input  logic rst_n,
  input  logic fsync,
  output logic start_evt,
  output logic locked
);

  logic fs_q;
  logic left_to_right;

  assign left_to_right = fs_q & ~fsync;
  assign start_evt     = left_to_right & ~locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q   <= 1'b0;
      locked <= 1'b0;
    end else begin
      fs_q <= fsync;
      if (start_evt) locked <= 1'b1;
    end
  end

endmodule

// File: rtl/cs_pos_counter.sv
module cs_pos_counter #(
  parameter int SUB_SLOTS    = 32,
  parameter int BLOCK_FRAMES = 192,
  localparam int FRAME_SLOTS = 2 * SUB_SLOTS,
  localparam int SW          = $clog2(FRAME_SLOTS),
  localparam int FW          = $clog2(BLOCK_FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_evt,
  input  logic          locked,
  output logic [SW-1:0] slot,
  output logic [FW-1:0] frame,
  output logic          frame_end
);

  import cs_seq_pkg::*;

  logic [SW-1:0] slot_nx;
  logic [FW-1:0] frame_nx;

  assign frame_end = (slot == SW'(FRAME_SLOTS - 1));

  always_comb begin
    slot_nx  = SW'(wrap_inc(int'(slot), FRAME_SLOTS));
    frame_nx = frame;
    if (frame_end) frame_nx = FW'(wrap_inc(int'(frame), BLOCK_FRAMES));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot  <= '0;
      frame <= '0;
    end else if (start_evt) begin
      slot  <= SW'(SUB_SLOTS);
      frame <= FW'(BLOCK_FRAMES - 1);
    end else if (locked) begin
      slot  <= slot_nx;
      frame <= frame_nx;
    end
  end

endmodule

// File: rtl/cs_blk_marker.sv
module cs_blk_marker #(
  parameter int SUB_SLOTS    = 32,
  parameter int BLOCK_FRAMES = 192,
  parameter int MARK_FRAMES  = 128,
  localparam int FRAME_SLOTS = 2 * SUB_SLOTS,
  localparam int SW          = $clog2(FRAME_SLOTS),
  localparam int FW          = $clog2(BLOCK_FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          locked,
  input  logic [SW-1:0] slot,
  input  logic [FW-1:0] frame,
  input  logic          subcode_en,
  output logic          blk_raw,
  output logic          rise_due,
  output logic          fall_due,
  output logic          blk_start,
  output logic          chan_b,
  output logic [1:0]    pre_sel
);

  import cs_seq_pkg::*;

  logic pre_last_slot;
  logic right_half;

  // Transitions are scheduled so the register changes entering slot 63.
  assign pre_last_slot = (slot == SW'(FRAME_SLOTS - 2));
  assign rise_due      = locked & pre_last_slot & (frame == FW'(BLOCK_FRAMES - 1));
  assign fall_due      = locked & pre_last_slot & (frame == FW'(MARK_FRAMES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        blk_raw <= 1'b0;
    else if (!locked)  blk_raw <= 1'b0;
    else if (rise_due) blk_raw <= 1'b1;
    else if (fall_due) blk_raw <= 1'b0;
  end

  assign right_half = (slot >= SW'(SUB_SLOTS));
  assign blk_start  = blk_raw & ~subcode_en;
  assign chan_b     = locked & right_half;
  assign pre_sel    = pick_preamble(locked, right_half, frame == '0);

endmodule

// File: rtl/cs_block_seq.sv
module cs_block_seq #(
  parameter int SUB_SLOTS    = 32,
  parameter int BLOCK_FRAMES = 192,
  parameter int MARK_FRAMES  = 128,
  localparam int FRAME_SLOTS = 2 * SUB_SLOTS,
  localparam int SW          = $clog2(FRAME_SLOTS),
  localparam int FW          = $clog2(BLOCK_FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fsync,
  input  logic          subcode_en,
  output logic [FW-1:0] frame_idx,
  output logic          chan_b,
  output logic [1:0]    pre_sel,
  output logic          blk_start,
  output logic          drv_en
);

  logic          start_evt;
  logic          locked;
  logic [SW-1:0] slot_q;
  logic [FW-1:0] frame_q;
  logic          frame_end;
  logic          blk_raw;
  logic          rise_due;
  logic          fall_due;

  cs_fsync_align u_align (
    .clk       (clk),
    .rst_n     (rst_n),
    .fsync     (fsync),
    .start_evt (start_evt),
    .locked    (locked)
  );

  cs_pos_counter #(
    .SUB_SLOTS    (SUB_SLOTS),
    .BLOCK_FRAMES (BLOCK_FRAMES)
  ) u_pos (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (start_evt),
    .locked    (locked),
    .slot      (slot_q),
    .frame     (frame_q),
    .frame_end (frame_end)
  );

  cs_blk_marker #(
    .SUB_SLOTS    (SUB_SLOTS),
    .BLOCK_FRAMES (BLOCK_FRAMES),
    .MARK_FRAMES  (MARK_FRAMES)
  ) u_mark (
    .clk        (clk),
    .rst_n      (rst_n),
    .locked     (locked),
    .slot       (slot_q),
    .frame      (frame_q),
    .subcode_en (subcode_en),
    .blk_raw    (blk_raw),
    .rise_due   (rise_due),
    .fall_due   (fall_due),
    .blk_start  (blk_start),
    .chan_b     (chan_b),
    .pre_sel    (pre_sel)
  );

  assign frame_idx = frame_q;
  assign drv_en    = locked;

endmodule

// File: rtl/cs_block_seq_chk.sv
module cs_block_seq_chk #(
  parameter int SUB_SLOTS    = 32,
  parameter int BLOCK_FRAMES = 192,
  parameter int MARK_FRAMES  = 128,
  localparam int FRAME_SLOTS = 2 * SUB_SLOTS,
  localparam int SW          = $clog2(FRAME_SLOTS),
  localparam int FW          = $clog2(BLOCK_FRAMES),
  localparam int HIGH_LEN    = MARK_FRAMES * FRAME_SLOTS,
  localparam int CW          = $clog2(HIGH_LEN + 2)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          subcode_en,
  input logic          drv_en,
  input logic          blk_start,
  input logic [1:0]    pre_sel,
  input logic          chan_b,
  input logic [FW-1:0] frame_idx,
  input logic [SW-1:0] slot,
  input logic          blk_raw
);

  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_cnt <= '0;
    else if (blk_raw) hi_cnt <= hi_cnt + 1'b1;
    else              hi_cnt <= '0;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> (!blk_start && pre_sel == 2'd0 && !chan_b && frame_idx == '0)); // R1

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && $past(drv_en)) |->
      (slot == (($past(slot) == SW'(FRAME_SLOTS - 1)) ? '0 : $past(slot) + 1'b1))); // R3

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && $past(drv_en) && $past(slot) == SW'(FRAME_SLOTS - 1) &&
     $past(frame_idx) == FW'(BLOCK_FRAMES - 1)) |-> frame_idx == '0); // R4

  AST_Z_ONLY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_sel == 2'd3) |-> (frame_idx == '0 && !chan_b)); // R5

  AST_Y_ON_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && chan_b) |-> pre_sel == 2'd2); // R5

  AST_RISE_SPOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk_raw) |-> (slot == SW'(FRAME_SLOTS - 1) && frame_idx == FW'(BLOCK_FRAMES - 1))); // R6

  AST_FALL_SPOT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blk_raw) |-> (slot == SW'(FRAME_SLOTS - 1) && frame_idx == FW'(MARK_FRAMES - 1))); // R7

  AST_HIGH_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(blk_raw) && drv_en) |-> hi_cnt == CW'(HIGH_LEN)); // R7

  AST_SUB_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    subcode_en |-> !blk_start); // R8

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(drv_en) |-> drv_en); // R9

endmodule

bind cs_block_seq cs_block_seq_chk #(
  .SUB_SLOTS    (SUB_SLOTS),
  .BLOCK_FRAMES (BLOCK_FRAMES),
  .MARK_FRAMES  (MARK_FRAMES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .subcode_en (subcode_en),
  .drv_en     (drv_en),
  .blk_start  (blk_start),
  .pre_sel    (pre_sel),
  .chan_b     (chan_b),
  .frame_idx  (frame_idx),
  .slot       (slot_q),
  .blk_raw    (blk_raw)
);

// File: tb/cs_block_seq_bench.sv
`timescale 1ns/1ps
module cs_block_seq_bench;

  localparam int SLOTS   = 64;
  localparam int FRAMES  = 192;
  localparam int BLK_LEN = SLOTS * FRAMES;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fsync = 1'b0;
  logic       subcode_en = 1'b0;
  logic [7:0] frame_idx;
  logic       chan_b;
  logic [1:0] pre_sel;
  logic       blk_start;
  logic       drv_en;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  cs_block_seq u_cs_block_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .fsync      (fsync),
    .subcode_en (subcode_en),
    .frame_idx  (frame_idx),
    .chan_b     (chan_b),
    .pre_sel    (pre_sel),
    .blk_start  (blk_start),
    .drv_en     (drv_en)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_idle(input string req);
    chk(req, "drv_en", drv_en, 0);
    chk(req, "blk_start", blk_start, 0);
    chk(req, "pre_sel", pre_sel, 0);
    chk(req, "chan_b", chan_b, 0);
    chk(req, "frame_idx", frame_idx, 0);
  endtask

  // Expected outputs derived from the linear position p = frame*64 + slot.
  task automatic chk_pos(input int p, input logic sub);
    int fr;
    int sl;
    int epre;
    int eblk;
    fr = p / SLOTS;
    sl = p % SLOTS;
    if (sl >= 32)     epre = 2;
    else if (fr == 0) epre = 3;
    else              epre = 1;
    eblk = ((p == BLK_LEN - 1) || (p <= 127 * SLOTS + 62)) ? 1 : 0;
    if (sub) eblk = 0;
    chk("R9", "drv_en", drv_en, 1);
    chk("R4", "frame_idx", frame_idx, fr);
    chk("R3", "chan_b", chan_b, (sl >= 32) ? 1 : 0);
    chk("R5", "pre_sel", pre_sel, epre);
    if (sub)                     chk("R8", "blk_start", blk_start, eblk);
    else if (p == BLK_LEN - 1)   chk("R6", "blk_start", blk_start, eblk);
    else                         chk("R7", "blk_start", blk_start, eblk);
  endtask

  // Run from alignment: first observed position is slot 32 of frame 191 (R2).
  task automatic run_locked(input int cycles, input bit use_sub);
    int p;
    p = 191 * SLOTS + 32;
    chk("R2", "drv_en after align", drv_en, 1);
    chk("R2", "frame at align", frame_idx, 191);
    chk("R2", "chan at align", chan_b, 1);
    for (int i = 0; i < cycles; i++) begin
      fsync = ((i / 37) % 2 == 0);
      if (use_sub)
        subcode_en = ((p >= BLK_LEN - 4) || (p <= 3) ||
                      (p >= 127 * SLOTS + 60 && p <= 128 * SLOTS + 2)) && (i < BLK_LEN);
      else
        subcode_en = 1'b0;
      #1;
      chk_pos(p, subcode_en);
      tick();
      p = (p + 1) % BLK_LEN;
    end
    subcode_en = 1'b0;
  endtask

  initial begin
    #(400_000 * 10);
    n_bad++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset with activity on fsync.
    for (int i = 0; i < 4; i++) begin
      fsync = i[0];
      tick();
      chk_idle("R1");
    end
    fsync = 1'b0;
    rst_n = 1'b1;
    // R2: fsync held low, no alignment.
    for (int i = 0; i < 10; i++) begin
      tick();
      chk_idle("R2");
    end
    fsync = 1'b1;
    for (int i = 0; i < 32; i++) begin
      tick();
      chk_idle("R2");
    end
    fsync = 1'b0;
    tick();
    run_locked(2 * BLK_LEN + 200, 1'b1);

    // Reset mid-block, then realign with a different fsync phase.
    rst_n = 1'b0;
    #1;
    chk_idle("R1");
    tick();
    chk_idle("R1");
    fsync = 1'b1;
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk_idle("R2");
    end
    fsync = 1'b0;
    tick();
    run_locked(BLK_LEN + 100, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule